// File: doc/BRIEF.md
# Scalar Floating-Point Unordered Compare Unit

This block compares two scalar IEEE-754 operands and reports the outcome as a three-bit condition code, written into the zero, parity and carry positions of a processor flags word. The operand width is chosen at build time: one parameter picks single or double precision. A NaN in either operand gives a separate "unordered" code. A quiet NaN gives that code without signalling anything. A signaling NaN also raises the invalid-operation status.

Each compare also receives the current control/status word. This word supplies the invalid and denormal exception masks and the denormals-are-zero control. The unit returns the word with any newly raised status ORed in, so status bits are sticky. If a raised exception is unmasked, the flags write is suppressed and a trap request is raised in its place. All outputs are registered and appear one cycle after the input strobe.

Top module: `fp_ucmp_unit`

## Requirements
- R1: For ordered operands, the flags word (CF at bit 0, PF at bit 2, ZF at bit 6) holds {ZF,PF,CF} = 1,0,0 for equal, 0,0,0 for a greater than b, and 0,0,1 for a less than b.
- R2: If either operand is a NaN (all-ones exponent, non-zero fraction), {ZF,PF,CF} = 1,1,1.
- R3: On every flags write, AF (bit 4), SF (bit 7), OF (bit 11) and all other bits of the flags word are 0.
- R4: Invalid status (status bit 0) is raised only when an operand is a signaling NaN, meaning the fraction MSB is 0. A quiet NaN (fraction MSB 1) raises nothing.
- R5: With denormals-are-zero (control bit 6) clear, a denormal operand (zero exponent, non-zero fraction) raises denormal status (status bit 1) and is compared by its value.
- R6: With denormals-are-zero set, denormal operands compare as zeros of their sign, and denormal status is not raised.
- R7: Positive and negative zero compare equal.
- R8: If a raised status is unmasked (invalid mask at control bit 7, denormal mask at bit 8, where 1 means masked), the flags write-enable stays low, the flags output keeps its previous value, and the trap request is high for that result.
- R9: The status output equals the incoming control/status word with the new status bits ORed in. No bit is ever cleared.
- R10: The result-valid output rises exactly one cycle after the input strobe. The flags write-enable and the trap request are asserted only together with result-valid, and never both at once.
- R11: If any operand is a NaN, denormal status is not raised, even when the other operand is a denormal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| op_a | input | OP_W | First operand |
| op_b | input | OP_W | Second operand |
| ctl_word | input | CTL_W | Current control/status word |
| valid_out | output | 1 | Result valid, one cycle after in_valid |
| flags_out | output | 12 | Flags word result |
| flags_we | output | 1 | Flags word write-enable |
| stat_out | output | CTL_W | Control/status word with sticky status merged |
| trap_req | output | 1 | Unmasked exception trap request |

## Verification
Two functions can fall in the same cycle: the NaN decision and the denormal decision. A NaN must override any denormal status carried by the other operand, and a masked or unmasked exception decides whether the flags are written or a trap is requested. The bench pairs a quiet NaN with a denormal under fully unmasked controls and expects an unordered write with no status and no trap. It pairs a signaling NaN and a denormal under an unmasked invalid, and a plain denormal under an unmasked denormal mask, and expects in both cases that the flags output holds its earlier value while the trap request rises.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  localparam int FLAG_W = 12;

  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int OF_POS = 11;

  localparam int ST_INV_POS  = 0;
  localparam int ST_DEN_POS  = 1;
  localparam int CT_DAZ_POS  = 6;
  localparam int MSK_INV_POS = 7;
  localparam int MSK_DEN_POS = 8;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_GT = 2'd1,
    CMP_LT = 2'd2,
    CMP_UN = 2'd3
  } cmp_res_e;

  function automatic logic [FLAG_W-1:0] encode_flags(input cmp_res_e r);
    logic [FLAG_W-1:0] f;
    f = '0;
    unique case (r)
      CMP_EQ: f[ZF_POS] = 1'b1;
      CMP_GT: f = '0;
      CMP_LT: f[CF_POS] = 1'b1;
      CMP_UN: begin
        f[ZF_POS] = 1'b1;
        f[PF_POS] = 1'b1;
        f[CF_POS] = 1'b1;
      end
      default: f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int OP_W = 1 + EXP_W + MAN_W
) (
  input  logic [OP_W-1:0] opnd,
  input  logic            daz,
  output logic            is_nan,
  output logic            is_snan,
  output logic            is_den,
  output logic            is_zero,
  output logic [OP_W-1:0] key
);
  logic              sgn;
  logic [EXP_W-1:0]  expo;
  logic [MAN_W-1:0]  frac;
  logic [OP_W-2:0]   mag;

  assign sgn  = opnd[OP_W-1];
  assign expo = opnd[OP_W-2 -: EXP_W];
  assign frac = opnd[MAN_W-1:0];

  always_comb begin
    is_nan  = (&expo) && (|frac);
    is_snan = is_nan && !frac[MAN_W-1];
    is_den  = (expo == '0) && (|frac);
    is_zero = ((expo == '0) && (frac == '0)) || (daz && is_den);
    mag     = {expo, frac};
    if (is_zero) begin
      key = {1'b1, {(OP_W-1){1'b0}}};
    end else if (!sgn) begin
      key = {1'b1, mag};
    end else begin
      key = {1'b0, ~mag};
    end
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic            nan_a,
  input  logic            nan_b,
  input  logic            zero_a,
  input  logic            zero_b,
  input  logic [OP_W-1:0] key_a,
  input  logic [OP_W-1:0] key_b,
  output cmp_res_e        res
);
  always_comb begin
    if (nan_a || nan_b) begin
      res = CMP_UN;
    end else if (zero_a && zero_b) begin
      res = CMP_EQ;
    end else if (key_a == key_b) begin
      res = CMP_EQ;
    end else if (key_a > key_b) begin
      res = CMP_GT;
    end else begin
      res = CMP_LT;
    end
  end
endmodule

// File: rtl/fpcmp_except.sv
module fpcmp_except (
  input  logic nan_a,
  input  logic nan_b,
  input  logic snan_a,
  input  logic snan_b,
  input  logic den_a,
  input  logic den_b,
  input  logic daz,
  input  logic mask_inv,
  input  logic mask_den,
  output logic raise_inv,
  output logic raise_den,
  output logic trap
);
  always_comb begin
    raise_inv = snan_a || snan_b;
    raise_den = !daz && (den_a || den_b) && !(nan_a || nan_b);
    trap      = (raise_inv && !mask_inv) || (raise_den && !mask_den);
  end
endmodule

// File: rtl/fp_ucmp_unit.sv
module fp_ucmp_unit
  import fpcmp_pkg::*;
#(
  parameter bit DOUBLE_PREC = 1'b0,
  parameter int CTL_W       = 32,
  localparam int EXP_W = DOUBLE_PREC ? 11 : 8,
  localparam int MAN_W = DOUBLE_PREC ? 52 : 23,
  localparam int OP_W  = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic [CTL_W-1:0]  ctl_word,
  output logic              valid_out,
  output logic [FLAG_W-1:0] flags_out,
  output logic              flags_we,
  output logic [CTL_W-1:0]  stat_out,
  output logic              trap_req
);
  localparam int NOPS = 2;

  logic [OP_W-1:0] opnd [NOPS];
  logic [OP_W-1:0] key  [NOPS];
  logic [NOPS-1:0] is_nan, is_snan, is_den, is_zero;
  logic            daz;
  cmp_res_e        res;
  logic            raise_inv, raise_den, trap;
  logic [CTL_W-1:0] stat_nxt;

  assign daz     = ctl_word[CT_DAZ_POS];
  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    fpcmp_classify #(
      .EXP_W(EXP_W),
      .MAN_W(MAN_W)
    ) u_cls (
      .opnd   (opnd[i]),
      .daz    (daz),
      .is_nan (is_nan[i]),
      .is_snan(is_snan[i]),
      .is_den (is_den[i]),
      .is_zero(is_zero[i]),
      .key    (key[i])
    );
  end

  fpcmp_order #(.OP_W(OP_W)) u_ord (
    .nan_a (is_nan[0]),
    .nan_b (is_nan[1]),
    .zero_a(is_zero[0]),
    .zero_b(is_zero[1]),
    .key_a (key[0]),
    .key_b (key[1]),
    .res   (res)
  );

  fpcmp_except u_exc (
    .nan_a    (is_nan[0]),
    .nan_b    (is_nan[1]),
    .snan_a   (is_snan[0]),
    .snan_b   (is_snan[1]),
    .den_a    (is_den[0]),
    .den_b    (is_den[1]),
    .daz      (daz),
    .mask_inv (ctl_word[MSK_INV_POS]),
    .mask_den (ctl_word[MSK_DEN_POS]),
    .raise_inv(raise_inv),
    .raise_den(raise_den),
    .trap     (trap)
  );

  always_comb begin
    stat_nxt = ctl_word;
    stat_nxt[ST_INV_POS] = ctl_word[ST_INV_POS] | raise_inv;
    stat_nxt[ST_DEN_POS] = ctl_word[ST_DEN_POS] | raise_den;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      flags_out <= '0;
      flags_we  <= 1'b0;
      stat_out  <= '0;
      trap_req  <= 1'b0;
    end else begin
      valid_out <= in_valid;
      flags_we  <= in_valid && !trap;
      trap_req  <= in_valid && trap;
      if (in_valid) begin
        stat_out <= stat_nxt;
        if (!trap) begin
          flags_out <= encode_flags(res);
        end
      end
    end
  end
endmodule

// File: rtl/fp_ucmp_checker.sv
module fp_ucmp_checker
  import fpcmp_pkg::*;
#(
  parameter int CTL_W = 32,
  parameter int OP_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   op_a,
  input logic [CTL_W-1:0]  ctl_word,
  input logic              valid_out,
  input logic [FLAG_W-1:0] flags_out,
  input logic              flags_we,
  input logic [CTL_W-1:0]  stat_out,
  input logic              trap_req
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> valid_out); // R10
  AST_WE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> valid_out); // R10
  AST_TRAP_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> valid_out); // R10
  AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trap_req, flags_we})); // R8
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !flags_we |-> $stable(flags_out)); // R8
  AST_AUX_FLAGS_ZERO: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (!flags_out[AF_POS] && !flags_out[SF_POS] && !flags_out[OF_POS])); // R3
  AST_PARITY_ONLY_UNORD: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (flags_out[PF_POS] == (flags_out[ZF_POS] && flags_out[CF_POS]))); // R2
  AST_NO_ZF_WITH_CF_ORDERED: assert property (@(posedge clk) disable iff (rst)
    (flags_we && !flags_out[PF_POS]) |-> ($countones({flags_out[ZF_POS], flags_out[CF_POS]}) <= 1)); // R1
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((stat_out & $past(ctl_word)) == $past(ctl_word))); // R9
endmodule

bind fp_ucmp_unit fp_ucmp_checker #(
  .CTL_W(CTL_W),
  .OP_W (OP_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op_a     (op_a),
  .ctl_word (ctl_word),
  .valid_out(valid_out),
  .flags_out(flags_out),
  .flags_we (flags_we),
  .stat_out (stat_out),
  .trap_req (trap_req)
);

// File: tb/fp_ucmp_unit_test.sv
`timescale 1ns/1ps
module fp_ucmp_unit_test;
  localparam int OP_W  = 32;
  localparam int CTL_W = 32;

  localparam logic [31:0] P_ONE  = 32'h3F80_0000;
  localparam logic [31:0] P_TWO  = 32'h4000_0000;
  localparam logic [31:0] N_ONE  = 32'hBF80_0000;
  localparam logic [31:0] N_TWO  = 32'hC000_0000;
  localparam logic [31:0] P_ZERO = 32'h0000_0000;
  localparam logic [31:0] N_ZERO = 32'h8000_0000;
  localparam logic [31:0] P_INF  = 32'h7F80_0000;
  localparam logic [31:0] Q_NAN  = 32'h7FC0_0000;
  localparam logic [31:0] S_NAN  = 32'h7F80_0001;
  localparam logic [31:0] P_DEN  = 32'h0000_0001;
  localparam logic [31:0] N_DEN  = 32'h8000_0001;

  localparam logic [11:0] F_EQ = 12'h040;
  localparam logic [11:0] F_GT = 12'h000;
  localparam logic [11:0] F_LT = 12'h001;
  localparam logic [11:0] F_UN = 12'h045;

  localparam logic [31:0] M_ALL = 32'h0000_0180;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [OP_W-1:0]  op_a = '0;
  logic [OP_W-1:0]  op_b = '0;
  logic [CTL_W-1:0] ctl_word = '0;
  logic             valid_out;
  logic [11:0]      flags_out;
  logic             flags_we;
  logic [CTL_W-1:0] stat_out;
  logic             trap_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  fp_ucmp_unit #(.DOUBLE_PREC(1'b0), .CTL_W(CTL_W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .ctl_word(ctl_word), .valid_out(valid_out), .flags_out(flags_out),
    .flags_we(flags_we), .stat_out(stat_out), .trap_req(trap_req)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive one compare and sample on the falling edge after the register edge.
  task automatic run_cmp(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk);
    op_a = a; op_b = b; ctl_word = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_write(input string req, input logic [11:0] f, input logic [31:0] st);
    chk({req, " valid"}, {31'd0, valid_out}, 32'd1);
    chk({req, " we"}, {31'd0, flags_we}, 32'd1);
    chk({req, " trap"}, {31'd0, trap_req}, 32'd0);
    chk({req, " flags"}, {20'd0, flags_out}, {20'd0, f});
    chk({req, " status"}, stat_out, st);
  endtask

  task automatic expect_trap(input string req, input logic [11:0] held, input logic [31:0] st);
    chk({req, " valid"}, {31'd0, valid_out}, 32'd1);
    chk({req, " we"}, {31'd0, flags_we}, 32'd0);
    chk({req, " trap"}, {31'd0, trap_req}, 32'd1);
    chk({req, " flags held"}, {20'd0, flags_out}, {20'd0, held});
    chk({req, " status"}, stat_out, st);
  endtask

  task automatic t_reset;
    chk("R10 reset valid", {31'd0, valid_out}, 32'd0);
    chk("R10 reset we", {31'd0, flags_we}, 32'd0);
    chk("R10 reset trap", {31'd0, trap_req}, 32'd0);
    chk("R3 reset flags", {20'd0, flags_out}, 32'd0);
  endtask

  task automatic t_ordered;
    run_cmp(P_ONE, P_ONE, M_ALL);  expect_write("R1 eq", F_EQ, M_ALL);
    run_cmp(P_TWO, P_ONE, M_ALL);  expect_write("R1 gt", F_GT, M_ALL);
    run_cmp(N_ONE, P_ONE, M_ALL);  expect_write("R1 lt sign", F_LT, M_ALL);
    run_cmp(N_TWO, N_ONE, M_ALL);  expect_write("R1 lt neg", F_LT, M_ALL);
    run_cmp(P_INF, P_TWO, M_ALL);  expect_write("R1 inf gt", F_GT, M_ALL);
    run_cmp(N_ZERO, N_ONE, M_ALL); expect_write("R1 zero gt neg", F_GT, M_ALL);
  endtask

  task automatic t_idle_after;
    @(negedge clk);
    chk("R10 idle valid", {31'd0, valid_out}, 32'd0);
    chk("R10 idle we", {31'd0, flags_we}, 32'd0);
  endtask

  task automatic t_zero_sign;
    run_cmp(P_ZERO, N_ZERO, M_ALL); expect_write("R7 +0 -0", F_EQ, M_ALL);
  endtask

  task automatic t_nan;
    run_cmp(Q_NAN, P_ONE, 32'h0);  expect_write("R2 R4 qnan quiet", F_UN, 32'h0);
    run_cmp(P_ONE, S_NAN, M_ALL);  expect_write("R4 snan masked", F_UN, M_ALL | 32'h1);
    run_cmp(P_TWO, P_ONE, M_ALL);  expect_write("R1 prime", F_GT, M_ALL);
    run_cmp(S_NAN, P_ONE, 32'h0);  expect_trap("R8 snan unmasked", F_GT, 32'h1);
  endtask

  task automatic t_denorm;
    run_cmp(P_DEN, P_ZERO, M_ALL); expect_write("R5 den gt zero", F_GT, M_ALL | 32'h2);
    run_cmp(N_DEN, P_DEN, M_ALL);  expect_write("R5 den lt", F_LT, M_ALL | 32'h2);
    run_cmp(P_DEN, P_ONE, 32'h080); expect_trap("R8 den unmasked", F_LT, 32'h082);
  endtask

  task automatic t_daz;
    run_cmp(P_DEN, N_ZERO, 32'h040); expect_write("R6 daz den eq zero", F_EQ, 32'h040);
    run_cmp(N_DEN, P_DEN, 32'h040);  expect_write("R6 daz den pair eq", F_EQ, 32'h040);
    run_cmp(N_DEN, P_ONE, 32'h040);  expect_write("R6 daz lt", F_LT, 32'h040);
  endtask

  task automatic t_nan_vs_den;
    run_cmp(Q_NAN, P_DEN, 32'h0); expect_write("R11 qnan den", F_UN, 32'h0);
    run_cmp(P_ONE, P_TWO, M_ALL); expect_write("R1 prime lt", F_LT, M_ALL);
    run_cmp(P_DEN, S_NAN, 32'h100); expect_trap("R11 snan den", F_LT, 32'h101);
  endtask

  task automatic t_sticky;
    run_cmp(P_ONE, P_TWO, 32'h183);  expect_write("R9 keep set", F_LT, 32'h183);
    run_cmp(P_DEN, P_ONE, 32'h5A1);  expect_write("R9 merge", F_LT, 32'h5A3);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ordered();
    t_idle_after();
    t_zero_sign();
    t_nan();
    t_denorm();
    t_daz();
    t_nan_vs_den();
    t_sticky();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule